// File: doc/BRIEF.md
# Load/Store Address Generator

This unit works out where a single-register load or store goes in memory and what the base register should hold afterwards. A request carries a 32-bit base, a 12-bit unsigned constant and a 32-bit register offset (already shifted by the operand shifter upstream), plus four control bits:
- offset source
- add/subtract
- pre/post indexing
- base-update request

The load/store direction bit travels alongside the request unchanged.

The offset is added to or subtracted from the base. A pre-indexed access uses that result as its address, and updates the base only when asked. A post-indexed access uses the untouched base as its address, and always updates the base.

The results appear combinationally in the same cycle as the request. A one-entry response register then offers a copy of them on a valid/ready stream. The request side is accepted (`req_ready` high) whenever the response slot is empty or is being drained in the same cycle. While the consumer holds `rsp_ready` low with a response pending, the response stays frozen and no new request is taken.

Top module: `ldst_agu`

## Requirements
- R1: With `req_use_reg`=0 the offset is `req_imm` zero-extended to 32 bits, so bit 11 set never makes it negative. With `req_use_reg`=1 the offset is `req_reg_off` used whole.
- R2: With `req_up`=1 the updated base `comb_new_base` is base plus offset; with `req_up`=0 it is base minus offset. Both wrap modulo 2^32.
- R3: With `req_pre`=1 the address `comb_addr` equals the updated base value.
- R4: With `req_pre`=0 the address `comb_addr` equals `req_base` unchanged, while `comb_new_base` still carries the offset result.
- R5: `comb_wb_en` is 1 for every post-indexed request (`req_pre`=0), whatever `req_wb` is. For pre-indexed requests it follows `req_wb`.
- R6: `comb_load` and `rsp_load` repeat the `req_load` bit of the request they belong to (1 = load, 0 = store).
- R7: The `comb_*` outputs reflect the request in the same cycle, with no clock edge in between.
- R8: A request accepted (`req_valid` and `req_ready` both 1) at a clock edge appears on `rsp_valid`/`rsp_*` right after that edge, carrying that request's results.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and every `rsp_*` output holds its value. `req_ready` is 1 whenever `rsp_valid` is 0.
- R10: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_base | input | 32 | Base register value |
| req_imm | input | 12 | Unsigned constant offset |
| req_reg_off | input | 32 | Pre-shifted register offset |
| req_use_reg | input | 1 | 1 selects the register offset, 0 the constant |
| req_up | input | 1 | 1 adds the offset, 0 subtracts it |
| req_pre | input | 1 | 1 pre-indexed, 0 post-indexed |
| req_wb | input | 1 | Base update request for pre-indexed forms |
| req_load | input | 1 | 1 load, 0 store |
| comb_addr | output | 32 | Memory address, same cycle |
| comb_new_base | output | 32 | Updated base value, same cycle |
| comb_wb_en | output | 1 | Base write enable, same cycle |
| comb_load | output | 1 | Direction flag, same cycle |
| rsp_valid | output | 1 | Registered response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_addr | output | 32 | Registered memory address |
| rsp_new_base | output | 32 | Registered updated base |
| rsp_wb_en | output | 1 | Registered base write enable |
| rsp_load | output | 1 | Registered direction flag |

## Verification
The checker watches several rules every clock:
- the address choice for pre and post indexing, and the forced base update on post-indexed forms
- the add path for both offset sources, and the pass-through of the direction bit
- capture of accepted requests into the response slot
- the freeze of a stalled response

Some cases only the directed scenarios in the bench show: subtraction that wraps below zero, a constant with bit 11 set staying positive, and a request held waiting behind a stall and then taken once the slot drains.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic {
    OFF_IMM = 1'b0,
    OFF_REG = 1'b1
  } off_src_e;
endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
  import agu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input  off_src_e         src,
  input  logic [IW-1:0]    imm,
  input  logic [DW-1:0]    reg_off,
  output logic [DW-1:0]    off
);
  localparam int PAD = DW - IW;
  logic [DW-1:0] imm_ext;

  generate
    if (PAD > 0) begin : g_pad
      assign imm_ext = {{PAD{1'b0}}, imm};
    end else begin : g_nopad
      assign imm_ext = imm[DW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      OFF_REG: off = reg_off;
      default: off = imm_ext;
    endcase
  end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] off,
  input  logic          up,
  output logic [DW-1:0] result
);
  logic [DW-1:0] operand;
  logic          cin;

  // One adder: subtraction is base + ~off + 1.
  assign operand = up ? off : ~off;
  assign cin     = ~up;
  assign result  = base + operand + {{(DW-1){1'b0}}, cin};
endmodule

// File: rtl/agu_index_sel.sv
module agu_index_sel #(
  parameter int DW = 32
) (
  input  logic          pre,
  input  logic          wb_req,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] updated,
  output logic [DW-1:0] addr,
  output logic          wb_en
);
  assign addr  = pre ? updated : base;
  assign wb_en = pre ? wb_req : 1'b1;
endmodule

// File: rtl/agu_rsp_reg.sv
module agu_rsp_reg #(
  parameter int PW = 66
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import agu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_base,
  input  logic [IW-1:0] req_imm,
  input  logic [DW-1:0] req_reg_off,
  input  logic          req_use_reg,
  input  logic          req_up,
  input  logic          req_pre,
  input  logic          req_wb,
  input  logic          req_load,
  output logic [DW-1:0] comb_addr,
  output logic [DW-1:0] comb_new_base,
  output logic          comb_wb_en,
  output logic          comb_load,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_new_base,
  output logic          rsp_wb_en,
  output logic          rsp_load
);
  localparam int PW = 2 * DW + 2;

  logic [DW-1:0] offset;
  logic [PW-1:0] pay_in, pay_out;
  off_src_e      src;

  assign src = req_use_reg ? OFF_REG : OFF_IMM;

  agu_offset_sel #(.DW(DW), .IW(IW)) u_off (
    .src(src), .imm(req_imm), .reg_off(req_reg_off), .off(offset)
  );

  agu_addsub #(.DW(DW)) u_add (
    .base(req_base), .off(offset), .up(req_up), .result(comb_new_base)
  );

  agu_index_sel #(.DW(DW)) u_idx (
    .pre(req_pre), .wb_req(req_wb), .base(req_base),
    .updated(comb_new_base), .addr(comb_addr), .wb_en(comb_wb_en)
  );

  assign comb_load = req_load;
  assign pay_in    = {comb_addr, comb_new_base, comb_wb_en, comb_load};

  agu_rsp_reg #(.PW(PW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_addr, rsp_new_base, rsp_wb_en, rsp_load} = pay_out;
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [DW-1:0] req_base,
  input logic [IW-1:0] req_imm,
  input logic [DW-1:0] req_reg_off,
  input logic          req_use_reg,
  input logic          req_up,
  input logic          req_pre,
  input logic          req_wb,
  input logic          req_load,
  input logic [DW-1:0] comb_addr,
  input logic [DW-1:0] comb_new_base,
  input logic          comb_wb_en,
  input logic          comb_load,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_addr,
  input logic [DW-1:0] rsp_new_base,
  input logic          rsp_wb_en,
  input logic          rsp_load
);
  // R1
  reg_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_use_reg && req_up |-> comb_new_base == req_base + req_reg_off);

  // R2
  imm_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_use_reg && req_up |-> comb_new_base == req_base + {{(DW-IW){1'b0}}, req_imm});

  // R3
  pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pre |-> comb_addr == comb_new_base);

  // R4
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_pre |-> comb_addr == req_base);

  // R5
  post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_pre |-> comb_wb_en);

  // R5
  pre_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pre && !req_wb |-> !comb_wb_en);

  // R6
  dir_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_load == req_load);

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid && rsp_addr == $past(comb_addr)
      && rsp_new_base == $past(comb_new_base) && rsp_load == $past(comb_load));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr)
      && $stable(rsp_new_base) && $stable(rsp_wb_en) && $stable(rsp_load));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind ldst_agu ldst_agu_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_base(req_base), .req_imm(req_imm), .req_reg_off(req_reg_off),
  .req_use_reg(req_use_reg), .req_up(req_up), .req_pre(req_pre),
  .req_wb(req_wb), .req_load(req_load), .comb_addr(comb_addr),
  .comb_new_base(comb_new_base), .comb_wb_en(comb_wb_en),
  .comb_load(comb_load), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_new_base(rsp_new_base),
  .rsp_wb_en(rsp_wb_en), .rsp_load(rsp_load)
);

// File: tb/tb_ldst_agu.sv
`timescale 1ns/1ps
module tb_ldst_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [11:0] req_imm = '0;
  logic [31:0] req_reg_off = '0;
  logic        req_use_reg = 1'b0, req_up = 1'b0, req_pre = 1'b0;
  logic        req_wb = 1'b0, req_load = 1'b0;
  logic [31:0] comb_addr, comb_new_base, rsp_addr, rsp_new_base;
  logic        comb_wb_en, comb_load, rsp_valid, rsp_wb_en, rsp_load;
  logic        rsp_ready = 1'b1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  ldst_agu dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected results straight from the requirements.
  function automatic logic [31:0] m_off(input logic use_reg, input logic [11:0] imm,
                                        input logic [31:0] ro);
    return use_reg ? ro : {20'd0, imm};
  endfunction

  task automatic apply(input logic [31:0] b, input logic [11:0] imm, input logic [31:0] ro,
                       input logic ur, input logic up, input logic pre, input logic wb,
                       input logic ld);
    @(negedge clk);
    req_base = b; req_imm = imm; req_reg_off = ro; req_use_reg = ur;
    req_up = up; req_pre = pre; req_wb = wb; req_load = ld; req_valid = 1'b1;
  endtask

  // Drive one request with the response drained; check both the same-cycle and the registered results.
  task automatic run_case(input string tag, input logic [31:0] b, input logic [11:0] imm,
                          input logic [31:0] ro, input logic ur, input logic up,
                          input logic pre, input logic wb, input logic ld);
    logic [31:0] nb, ad;
    logic        we;
    nb = up ? b + m_off(ur, imm, ro) : b - m_off(ur, imm, ro);
    ad = pre ? nb : b;
    we = pre ? wb : 1'b1;
    apply(b, imm, ro, ur, up, pre, wb, ld);
    #1;
    chk({tag, " R7 comb_addr"}, comb_addr, ad);
    chk({tag, " R2 comb_new_base"}, comb_new_base, nb);
    chk({tag, " R5 comb_wb_en"}, {31'd0, comb_wb_en}, {31'd0, we});
    chk({tag, " R6 comb_load"}, {31'd0, comb_load}, {31'd0, ld});
    @(posedge clk); #1;
    chk({tag, " R8 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " R8 rsp_addr"}, rsp_addr, ad);
    chk({tag, " R8 rsp_new_base"}, rsp_new_base, nb);
    chk({tag, " R8 rsp_wb_en"}, {31'd0, rsp_wb_en}, {31'd0, we});
    chk({tag, " R6 rsp_load"}, {31'd0, rsp_load}, {31'd0, ld});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_pre_imm_up();
    run_case("R3 pre imm up wb", 32'h0000_1000, 12'h024, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_pre_no_wb();
    run_case("R5 pre no wb", 32'h2000_0000, 12'h100, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_post_forced_wb();
    run_case("R4 post wb0", 32'h0000_8000, 12'h010, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_imm_zero_ext();
    run_case("R1 imm bit11", 32'h0000_0000, 12'hFFF, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_sub_wrap();
    run_case("R2 sub wrap", 32'h0000_0010, 12'h020, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_reg_add_wrap();
    run_case("R1 reg add wrap", 32'hFFFF_FFF0, 12'h7FF, 32'h0000_0020, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_post_reg_down();
    run_case("R4 post reg down", 32'h1234_5678, 12'h000, 32'h0000_1678, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    apply(32'h0000_0100, 12'h004, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    chk("R8 stall first captured", rsp_addr, 32'h0000_0104);
    chk("R9 req_ready low", {31'd0, req_ready}, 32'd0);
    apply(32'h0000_0200, 12'h008, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R9 rsp_addr held", rsp_addr, 32'h0000_0104);
    chk("R9 rsp_new_base held", rsp_new_base, 32'h0000_0104);
    chk("R9 rsp_load held", {31'd0, rsp_load}, 32'd1);
    @(negedge clk);
    rsp_ready = 1'b1;
    #1;
    chk("R9 req_ready on drain", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R9 second taken addr", rsp_addr, 32'h0000_0200);
    chk("R9 second new_base", rsp_new_base, 32'h0000_01F8);
    chk("R5 second wb forced", {31'd0, rsp_wb_en}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 slot empties", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_pre_imm_up();
    t_pre_no_wb();
    t_post_forced_wb();
    t_imm_zero_ext();
    t_sub_wrap();
    t_reg_add_wrap();
    t_post_reg_down();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule